// File: doc/BRIEF.md
# Ordered Power and Reset Sequencer for a Block Chain

This controller brings up and shuts down a linear chain of N subsystems. In the chain, each subsystem's outputs feed the next one. For every subsystem it drives three signals: a power enable, an active-low reset, and a park request. Each subsystem answers the park request with a park acknowledge. It raises the acknowledge once it has clocked its outputs to their reset values. It also reports a ready signal after it leaves reset.

Bring-up runs from the head of the chain to the tail. For each subsystem the controller turns on its power and waits a programmable settle time. It then lets the subsystem leave reset, synchronous to that subsystem's own clock, and waits for its ready signal before moving to the next subsystem. This way no start-up transient from an upstream stage reaches the final output.

Shutdown treats the tail of the chain first. The tail subsystem is parked, reset and switched off on its own. All the other subsystems are then parked together, reset in one cycle and switched off together. A reset is never applied before the subsystem's acknowledge has passed through a two-flop synchroniser. If that acknowledge never arrives, the controller waits a bounded time, latches a sticky fault and applies the reset anyway.

Top module: `chain_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises with no request, every `pwr_en`, `blk_rst_n` and `park_req` bit is 0, and `busy` and `fault` are 0.
- R2: On a one-cycle `up_req` pulse with the chain off, bit i of `pwr_en` (bit 0 = head of the chain) rises only after `blk_ready[i-1]` has been seen high. At any time `pwr_en` holds a contiguous run of ones starting at bit 0. At the end of bring-up all bits of `pwr_en` and `blk_rst_n` are 1.
- R3: `blk_rst_n[i]` rises exactly PWR_WAIT+2 clock cycles after `pwr_en[i]` rises. The last two of those cycles come from a two-flop release stage clocked by `blk_clk[i]`. `blk_rst_n[i]` is never high while `pwr_en[i]` is low.
- R4: On a `down_req` pulse with the chain up, only `park_req[N-1]` is raised first. `blk_rst_n[N-1]` falls, and `pwr_en[N-1]` then clears, in a cycle strictly before any other `blk_rst_n` bit falls.
- R5: After the tail is off, `park_req` is raised for all remaining subsystems together. Their `blk_rst_n` bits all fall in the same cycle, then `pwr_en` becomes all zero, and the controller returns to idle.
- R6: A `blk_rst_n` bit falls while `rst_n` is high only if its `park_req` was already high. It also falls only after the matching `park_ack` has been received through a two-stage synchroniser, unless the timeout of R8 expires.
- R7: When one shutdown step is done, `park_req` for the subsystems of that step stays high until the whole chain is off.
- R8: If the acknowledges awaited by a shutdown step do not all arrive within ACK_TIMEOUT cycles, `fault` goes to 1 and stays there until `rst_n` is low. The step's resets are asserted anyway and shutdown completes.
- R9: `busy` is 1 while a bring-up or shutdown is running. `up_req` and `down_req` have no effect while busy. `up_req` has no effect with the chain up, and `down_req` has no effect with the chain off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller; also holds all subsystems in reset |
| up_req | input | 1 | Start bring-up (acted on only when idle with the chain off) |
| down_req | input | 1 | Start shutdown (acted on only when idle with the chain up) |
| blk_clk | input | N | Clock of each subsystem, used to release its reset |
| park_ack | input | N | Subsystem has parked its outputs at reset values (its own clock domain) |
| blk_ready | input | N | Subsystem is running after leaving reset (its own clock domain) |
| pwr_en | output | N | Power enable per subsystem, bit 0 = head of the chain |
| blk_rst_n | output | N | Active-low reset per subsystem: asserted asynchronously, released synchronously |
| park_req | output | N | Request for the subsystem to hold its outputs at reset values |
| busy | output | 1 | A sequence is in progress |
| fault | output | 1 | Sticky: an acknowledge timed out during shutdown |

## Verification
The bench varies how long subsystems take to acknowledge and to become ready, so an ordering bug is exposed by timing. A design that moved on before the previous ready would show an early enable time. A design that released reset without the settle count or the two-edge release stage would miss the exact PWR_WAIT+2 distance. On shutdown the bench records the cycle in which each reset falls and whether that subsystem's acknowledge had been seen first. A controller that reset everything at once, reset the rest one by one, or reset a subsystem before its park handshake fails those comparisons. Silent subsystems, one at the tail and one in the rest group, show whether a missing acknowledge hangs the controller or leaves the fault flag clear. Stray requests during and around sequences catch a controller that reverses or restarts a sequence in progress.

// File: rtl/chain_pwr_seq.sv
module chain_pwr_seq #(
  parameter int N           = 4,
  parameter int PWR_WAIT    = 4,
  parameter int ACK_TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_req,
  input  logic         down_req,
  input  logic [N-1:0] blk_clk,
  input  logic [N-1:0] park_ack,
  input  logic [N-1:0] blk_ready,
  output logic [N-1:0] pwr_en,
  output logic [N-1:0] blk_rst_n,
  output logic [N-1:0] park_req,
  output logic         busy,
  output logic         fault
);
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int CMAX = (PWR_WAIT > ACK_TIMEOUT) ? PWR_WAIT : ACK_TIMEOUT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  typedef enum logic [2:0] {
    S_OFF, S_PU_STEP, S_ON, S_PD_PARK_LAST, S_PD_OFF_LAST, S_PD_PARK_REST, S_PD_OFF_REST
  } st_t;

  st_t           state;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          settled;
  logic [N-1:0]  rel;
  logic [N-1:0]  ack_m, ack_s, rdy_m, rdy_s;

  wire [IW-1:0] idx_nxt   = idx + 1'b1;
  wire          settle_ok = (cnt == CW'(PWR_WAIT - 1));
  wire          ack_tmo   = (cnt == CW'(ACK_TIMEOUT - 1));
  wire          rest_ack  = &ack_s[N-2:0];

  assign busy = (state != S_OFF) && (state != S_ON);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_m <= '0; ack_s <= '0; rdy_m <= '0; rdy_s <= '0;
    end else begin
      ack_m <= park_ack;  ack_s <= ack_m;
      rdy_m <= blk_ready; rdy_s <= rdy_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_OFF;
      idx      <= '0;
      cnt      <= '0;
      settled  <= 1'b0;
      pwr_en   <= '0;
      rel      <= '0;
      park_req <= '0;
      fault    <= 1'b0;
    end else begin
      case (state)
        S_OFF:
          if (up_req) begin
            state     <= S_PU_STEP;
            idx       <= '0;
            cnt       <= '0;
            settled   <= 1'b0;
            pwr_en[0] <= 1'b1;
          end
        S_PU_STEP:
          if (!settled) begin
            if (settle_ok) begin
              rel[idx] <= 1'b1;
              settled  <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end else if (rdy_s[idx]) begin
            if (idx == LAST) state <= S_ON;
            else begin
              idx             <= idx_nxt;
              pwr_en[idx_nxt] <= 1'b1;
              cnt             <= '0;
              settled         <= 1'b0;
            end
          end
        S_ON:
          if (down_req) begin
            state         <= S_PD_PARK_LAST;
            park_req[N-1] <= 1'b1;
            cnt           <= '0;
          end
        S_PD_PARK_LAST:
          if (ack_s[N-1] || ack_tmo) begin
            if (!ack_s[N-1]) fault <= 1'b1;
            rel[N-1] <= 1'b0;
            state    <= S_PD_OFF_LAST;
          end else cnt <= cnt + 1'b1;
        S_PD_OFF_LAST: begin
          pwr_en[N-1]     <= 1'b0;
          park_req[N-2:0] <= '1;
          cnt             <= '0;
          state           <= S_PD_PARK_REST;
        end
        S_PD_PARK_REST:
          if (rest_ack || ack_tmo) begin
            if (!rest_ack) fault <= 1'b1;
            rel[N-2:0] <= '0;
            state      <= S_PD_OFF_REST;
          end else cnt <= cnt + 1'b1;
        S_PD_OFF_REST: begin
          pwr_en   <= '0;
          park_req <= '0;
          state    <= S_OFF;
        end
        default: state <= S_OFF;
      endcase
    end

  for (genvar g = 0; g < N; g++) begin : g_rst
    logic [1:0] q;
    wire hold = ~rst_n | ~rel[g];
    always_ff @(posedge blk_clk[g] or posedge hold)
      if (hold) q <= 2'b00;
      else      q <= {q[0], 1'b1};
    assign blk_rst_n[g] = q[1];
  end
endmodule

module chain_pwr_seq_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         up_req,
  input logic [N-1:0] pwr_en,
  input logic [N-1:0] blk_rst_n,
  input logic [N-1:0] park_req,
  input logic         busy,
  input logic         fault
);
  // R2
  pwr_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_en + 1'b1) & pwr_en) == '0);

  // R3
  rst_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_rst_n & ~pwr_en) == '0);

  // R4
  tail_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(blk_rst_n[N-2:0]) & ~blk_rst_n[N-2:0]) != '0) |-> !$past(blk_rst_n[N-1]));

  // R6
  park_before_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(blk_rst_n) & ~blk_rst_n & ~$past(park_req)) == '0);

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> fault);

  // R9
  idle_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_en == '0 && !up_req) |=> (pwr_en == '0 && !busy));
endmodule

bind chain_pwr_seq chain_pwr_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_req(up_req), .pwr_en(pwr_en),
  .blk_rst_n(blk_rst_n), .park_req(park_req), .busy(busy), .fault(fault)
);

// File: tb/sim_chain_pwr_seq.sv
module sim_chain_pwr_seq;
  localparam int N  = 4;
  localparam int PW = 4;
  localparam int TO = 40;

  // {ack delay[12:9], ready delay[8:5], silent mask[4:1], expected fault[0]}
  localparam logic [12:0] VEC [4] = '{
    {4'd1, 4'd1, 4'b0000, 1'b0},
    {4'd7, 4'd5, 4'b0000, 1'b0},
    {4'd2, 4'd0, 4'b1000, 1'b1},
    {4'd3, 4'd3, 4'b0010, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, up_req = 1'b0, down_req = 1'b0;
  logic [N-1:0] park_ack = '0, blk_ready = '0;
  wire  [N-1:0] blk_clk = {N{clk}};
  wire  [N-1:0] pwr_en, blk_rst_n, park_req;
  wire          busy, fault;

  always #2 clk = ~clk;

  chain_pwr_seq #(.N(N), .PWR_WAIT(PW), .ACK_TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
    .blk_clk(blk_clk), .park_ack(park_ack), .blk_ready(blk_ready),
    .pwr_en(pwr_en), .blk_rst_n(blk_rst_n), .park_req(park_req),
    .busy(busy), .fault(fault));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ack_dly = 0, rdy_dly = 0;
  logic [N-1:0] mute = '0, acked = '0;
  logic [N-1:0] p_en = '0, p_rst = '0, p_rdy = '0;
  int t_en [N], t_rel [N], t_rdy [N], t_fall [N];
  int ack_cnt [N], rdy_cnt [N];
  bit bad_rst = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      t_en[i] = 0; t_rel[i] = 0; t_rdy[i] = 0; t_fall[i] = 0;
      ack_cnt[i] = 0; rdy_cnt[i] = 0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = 0; i < N; i++) begin
        if (pwr_en[i] && !p_en[i]) t_en[i] = cyc;
        if (blk_rst_n[i] && !p_rst[i]) t_rel[i] = cyc;
        if (!blk_rst_n[i] && p_rst[i]) begin
          t_fall[i] = cyc;
          if (!acked[i] && !mute[i]) bad_rst = 1;
        end
        if (blk_ready[i] && !p_rdy[i]) t_rdy[i] = cyc;
        if (park_ack[i]) acked[i] = 1'b1;
      end
      p_en = pwr_en; p_rst = blk_rst_n; p_rdy = blk_ready;
      for (int i = 0; i < N; i++) begin
        if (park_req[i] && !mute[i]) begin
          if (ack_cnt[i] >= ack_dly) park_ack[i] = 1'b1;
          else ack_cnt[i]++;
        end else begin
          ack_cnt[i] = 0; park_ack[i] = 1'b0;
        end
        if (blk_rst_n[i]) begin
          if (rdy_cnt[i] >= rdy_dly) blk_ready[i] = 1'b1;
          else rdy_cnt[i]++;
        end else begin
          rdy_cnt[i] = 0; blk_ready[i] = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WD", "watchdog expired", cyc, 0);
    summary();
  end

  task automatic pulse(input bit up);
    @(negedge clk);
    if (up) up_req = 1'b1; else down_req = 1'b1;
    @(negedge clk);
    up_req = 1'b0; down_req = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
    chk(!busy, "R9", "sequence did not end", busy, 0);
  endtask

  task automatic run(input logic [12:0] v);
    logic exp_fault;
    ack_dly = int'(v[12:9]); rdy_dly = int'(v[8:5]); mute = v[4:1]; exp_fault = v[0];
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    acked = '0; bad_rst = 0;
    for (int i = 0; i < N; i++) begin t_en[i] = 0; t_rel[i] = 0; t_rdy[i] = 0; t_fall[i] = 0; end
    chk({pwr_en, blk_rst_n, park_req, busy, fault} == '0, "R1", "outputs in reset",
        {pwr_en, blk_rst_n, park_req, busy, fault}, 0);
    rst_n = 1'b1;
    pulse(1'b0);
    repeat (5) @(negedge clk);
    chk(pwr_en == '0 && !busy, "R9", "down_req while off ignored", pwr_en, 0);
    chk({pwr_en, blk_rst_n, park_req, busy, fault} == '0, "R1", "idle after reset",
        {pwr_en, blk_rst_n, park_req, busy, fault}, 0);

    pulse(1'b1);
    chk(busy, "R9", "busy during bring-up", busy, 1);
    repeat (3) @(negedge clk);
    pulse(1'b0);
    pulse(1'b1);
    wait_idle();
    chk(pwr_en == '1 && blk_rst_n == '1, "R2", "chain fully up",
        {pwr_en, blk_rst_n}, {N{2'b11}});
    chk(park_req == '0 && !fault, "R9", "no park/fault after bring-up", {park_req, fault}, 0);
    for (int i = 0; i < N; i++) begin
      chk(t_rel[i] - t_en[i] == PW + 2, "R3", $sformatf("release delay blk %0d", i),
          t_rel[i] - t_en[i], PW + 2);
      if (i > 0)
        chk(t_en[i] > t_rdy[i-1] && t_rdy[i-1] > 0, "R2",
            $sformatf("enable blk %0d after ready of %0d", i, i - 1), t_en[i], t_rdy[i-1] + 1);
    end

    pulse(1'b1);
    repeat (10) @(negedge clk);
    chk(pwr_en == '1 && !busy, "R9", "up_req while up ignored", {busy, pwr_en}, {1'b0, {N{1'b1}}});

    pulse(1'b0);
    chk(busy && park_req == {1'b1, {(N-1){1'b0}}}, "R4", "tail parked alone",
        park_req, {1'b1, {(N-1){1'b0}}});
    repeat (2) @(negedge clk);
    pulse(1'b1);
    wait_idle();
    chk(pwr_en == '0 && blk_rst_n == '0 && park_req == '0, "R5", "chain fully off",
        {pwr_en, blk_rst_n, park_req}, 0);
    for (int j = 0; j < N - 1; j++) begin
      chk(t_fall[N-1] < t_fall[j], "R4", $sformatf("tail reset before blk %0d", j),
          t_fall[N-1], t_fall[j]);
      chk(t_fall[j] == t_fall[0], "R5", $sformatf("rest reset together blk %0d", j),
          t_fall[j], t_fall[0]);
    end
    chk(!bad_rst, "R6", "reset only after acknowledge", bad_rst, 0);
    chk(fault == exp_fault, "R8", "fault flag after shutdown", fault, exp_fault);
    repeat (4) @(negedge clk);
    chk(fault == exp_fault, "R8", "fault flag held", fault, exp_fault);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int r = 0; r < 4; r++) run(VEC[r]);

    // R7: tail park request held during rest phase (slow acks)
    @(negedge clk);
    ack_dly = 9; rdy_dly = 1; mute = '0;
    pulse(1'b1);
    wait_idle();
    pulse(1'b0);
    while (park_req[0] == 1'b0) @(negedge clk);
    chk(park_req == '1 && pwr_en[N-1] == 1'b0, "R7", "all parks held in rest phase",
        {pwr_en[N-1], park_req}, {1'b0, {N{1'b1}}});
    wait_idle();
    summary();
  end
endmodule